// File: doc/BRIEF.md
# Rate and Burst Parameter Encoder

This block converts a requested traffic rate (bits per second, 64 bits) and a bucket depth (bytes, 32 bits) into the mantissa, exponent and divider fields that a token-bucket meter consumes. A single-cycle `start` strobe captures both inputs. The block then works through a short sequence of clocked steps and raises `done` for one cycle when all five result fields are valid. The results stay on the outputs until the next `done`.

The rate path multiplies the rate by 64. It then moves that value into the window [256,000,000, 512,000,000) one step per clock. Each doubling step adds one to the divider count, and each halving step adds one to the exponent count. The distance above the lower edge of the window is then divided by 1,000,000 with a fixed-divisor restoring divider, one quotient bit per clock. The burst path is a priority encoder with a clamped right shift, and its result is captured together with the rate fields.

The controller has four states. `ST_IDLE` moves to `ST_NORM` on `start`. `ST_NORM` steps the normalizer and moves to `ST_DIVIDE` once no further step applies. `ST_DIVIDE` runs the eight divider steps and moves to `ST_DONE` when the divider reports ready. `ST_DONE` lasts one cycle and returns to `ST_IDLE`.

Top module: `rate_burst_encoder`

## Requirements
- R1: The rate is scaled by 64. If the scaled value is below 256,000,000, it is doubled once per step and `rate_div` counts the doublings. The doubling stops when the value reaches at least 256,000,000 or when `rate_div` reaches 31, and `rate_exp` stays 0 on this path.
- R2: If the scaled value is 512,000,000 or more, it is halved once per step. Each halving adds one to the exponent count, and `rate_div` stays 0 on this path. Halving continues while the value is at least 512,000,000 and the count is at most 22.
- R3: `rate_exp` is the exponent count clamped to 22. A rate that needs 23 halvings reports 22.
- R4: `rate_mant` is (normalized value − 256,000,000) / 1,000,000, rounded down. It is 0 if the normalized value is still below 256,000,000 (rate 0). It saturates at 255 if the value is still at least 512,000,000 after the clamped halving.
- R5: `burst_exp` is floor(log2(burst)), and a burst of 0 gives `burst_exp` 0 and `burst_mant` 0.
- R6: For a burst below 256, `burst_mant` is 0 and `burst_exp` is not clamped.
- R7: For a burst of 256 or more, `burst_exp` is floor(log2) clamped to 22. `burst_mant` is (burst − 2^floor(log2 burst)) shifted right by (`burst_exp` − 8), saturating at 255.
- R8: `done` is high for exactly one cycle per accepted request. All result outputs change only in a cycle where `done` is high and hold their values otherwise.
- R9: A `start` pulse that arrives while a request is in progress (`ST_NORM`, `ST_DIVIDE` or `ST_DONE`) is ignored. It produces no extra `done`, and the results belong to the first request.
- R10: After reset, `done` is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture `rate` and `burst` and begin a conversion |
| rate | input | 64 | Requested rate in bits per second |
| burst | input | 32 | Requested burst size in bytes |
| done | output | 1 | One-cycle strobe: results valid |
| rate_mant | output | 8 | Rate mantissa |
| rate_exp | output | 5 | Rate exponent (0 to 22) |
| rate_div | output | 5 | Rate divider count |
| burst_mant | output | 8 | Burst mantissa |
| burst_exp | output | 5 | Burst exponent |

## Verification
Two things can fall in the same cycle: a new `start` strobe and a conversion that is still running. The bench starts one conversion and pulses `start` with different operands a few cycles later, while the controller is still normalizing. The bench then expects exactly one `done` and the first operands' results, and checks that no second `done` follows and that the outputs stay unchanged. The results are also compared with a bench model. The vectors cover the rate at every power of two, both clamp limits, and a burst sweep across the 256 boundary.

// File: rtl/rbe_pkg.sv
package rbe_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NORM,
        ST_DIVIDE,
        ST_DONE
    } rbe_state_e;
endpackage

// File: rtl/rbe_rate_norm.sv
module rbe_rate_norm #(
    parameter int RATE_W      = 64,
    parameter int SCALE_SHIFT = 6,
    parameter int EXP_W       = 5,
    parameter int DIV_W       = 5,
    parameter int EXP_MAX     = 22,
    parameter int unsigned LOW_MARK  = 256_000_000,
    parameter int unsigned HIGH_MARK = 512_000_000,
    localparam int SCL_W = RATE_W + SCALE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              active,
    input  logic [RATE_W-1:0] rate_in,
    output logic [SCL_W-1:0]  scaled,
    output logic [DIV_W-1:0]  div_cnt,
    output logic [EXP_W-1:0]  exp_cnt,
    output logic              settled
);
    localparam logic [SCL_W-1:0] LOW_V  = SCL_W'(LOW_MARK);
    localparam logic [SCL_W-1:0] HIGH_V = SCL_W'(HIGH_MARK);
    localparam logic [DIV_W-1:0] DIV_LIM = '1;
    localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(EXP_MAX);

    logic grow, shrink;

    always_comb begin
        grow    = (scaled < LOW_V) && (div_cnt != DIV_LIM);
        shrink  = (scaled >= HIGH_V) && (exp_cnt <= EXP_LIM);
        settled = !grow && !shrink;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scaled  <= '0;
            div_cnt <= '0;
            exp_cnt <= '0;
        end else if (load) begin
            scaled  <= SCL_W'(rate_in) << SCALE_SHIFT;
            div_cnt <= '0;
            exp_cnt <= '0;
        end else if (active && grow) begin
            scaled  <= scaled << 1;
            div_cnt <= div_cnt + 1'b1;
        end else if (active && shrink) begin
            scaled  <= scaled >> 1;
            exp_cnt <= exp_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rbe_const_div.sv
module rbe_const_div #(
    parameter int unsigned DIVISOR = 1_000_000,
    parameter int D_W   = 29,
    parameter int Q_W   = 8,
    localparam int CNT_W = $clog2(Q_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [D_W-1:0] dividend,
    output logic [Q_W-1:0] quotient,
    output logic           ready
);
    localparam logic [D_W-1:0] DIV_V = D_W'(DIVISOR);

    logic [D_W-1:0]   rem;
    logic [CNT_W-1:0] cnt;
    logic [D_W-1:0]   trial;
    logic             fits;

    always_comb begin
        trial = DIV_V << (cnt - 1'b1);
        fits  = (rem >= trial);
        ready = (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            cnt      <= '0;
            quotient <= '0;
        end else if (load) begin
            rem      <= dividend;
            cnt      <= CNT_W'(Q_W);
            quotient <= '0;
        end else if (!ready) begin
            if (fits) rem <= rem - trial;
            quotient <= {quotient[Q_W-2:0], fits};
            cnt      <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/rbe_burst_enc.sv
module rbe_burst_enc #(
    parameter int BURST_W = 32,
    parameter int MANT_W  = 8,
    parameter int EXP_MAX = 22,
    localparam int BE_W   = $clog2(BURST_W)
) (
    input  logic [BURST_W-1:0] burst,
    output logic [MANT_W-1:0]  mant,
    output logic [BE_W-1:0]    expo
);
    localparam logic [BURST_W-1:0] FLOOR_V  = BURST_W'(1) << MANT_W;
    localparam logic [BURST_W-1:0] MANT_TOP = BURST_W'((1 << MANT_W) - 1);
    localparam logic [BE_W-1:0]    EXP_LIM  = BE_W'(EXP_MAX);

    logic [BE_W-1:0]    msb;
    logic [BE_W-1:0]    eclamp;
    logic [BURST_W-1:0] rest;
    logic [BURST_W-1:0] shifted;

    always_comb begin
        msb = '0;
        for (int i = 0; i < BURST_W; i++) begin
            if (burst[i]) msb = BE_W'(i);
        end
        eclamp  = (msb > EXP_LIM) ? EXP_LIM : msb;
        rest    = burst & ~(BURST_W'(1) << msb);
        shifted = rest >> (eclamp - BE_W'(MANT_W));
        if (burst < FLOOR_V) begin
            mant = '0;
            expo = msb;
        end else begin
            mant = (shifted > MANT_TOP) ? '1 : shifted[MANT_W-1:0];
            expo = eclamp;
        end
    end
endmodule

// File: rtl/rate_burst_encoder.sv
module rate_burst_encoder
    import rbe_pkg::*;
#(
    parameter int RATE_W      = 64,
    parameter int BURST_W     = 32,
    parameter int MANT_W      = 8,
    parameter int EXP_W       = 5,
    parameter int DIV_W       = 5,
    parameter int EXP_MAX     = 22,
    parameter int SCALE_SHIFT = 6,
    parameter int unsigned LOW_MARK  = 256_000_000,
    parameter int unsigned HIGH_MARK = 512_000_000,
    parameter int unsigned STEP      = 1_000_000,
    localparam int BE_W = $clog2(BURST_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RATE_W-1:0]  rate,
    input  logic [BURST_W-1:0] burst,
    output logic               done,
    output logic [MANT_W-1:0]  rate_mant,
    output logic [EXP_W-1:0]   rate_exp,
    output logic [DIV_W-1:0]   rate_div,
    output logic [MANT_W-1:0]  burst_mant,
    output logic [BE_W-1:0]    burst_exp
);
    localparam int SCL_W = RATE_W + SCALE_SHIFT;
    localparam int D_W   = $clog2(LOW_MARK) + 1;
    localparam logic [SCL_W-1:0] LOW_V  = SCL_W'(LOW_MARK);
    localparam logic [SCL_W-1:0] HIGH_V = SCL_W'(HIGH_MARK);
    localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(EXP_MAX);

    rbe_state_e state, state_nxt;

    logic [SCL_W-1:0]   scaled;
    logic [DIV_W-1:0]   div_cnt;
    logic [EXP_W-1:0]   exp_cnt;
    logic               settled;
    logic [D_W-1:0]     diff;
    logic [MANT_W-1:0]  quotient;
    logic               div_ready;
    logic               sat_q;
    logic [BURST_W-1:0] burst_q;
    logic [MANT_W-1:0]  b_mant;
    logic [BE_W-1:0]    b_exp;
    logic               accept, to_divide, capture;

    always_comb begin
        accept    = (state == ST_IDLE) && start;
        to_divide = (state == ST_NORM) && settled;
        capture   = (state == ST_DIVIDE) && div_ready;
        diff      = (scaled >= LOW_V) ? D_W'(scaled - LOW_V) : '0;
        done      = (state == ST_DONE);
    end

    rbe_rate_norm #(
        .RATE_W(RATE_W), .SCALE_SHIFT(SCALE_SHIFT), .EXP_W(EXP_W),
        .DIV_W(DIV_W), .EXP_MAX(EXP_MAX),
        .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK)
    ) u_norm (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .active(state == ST_NORM), .rate_in(rate),
        .scaled(scaled), .div_cnt(div_cnt), .exp_cnt(exp_cnt),
        .settled(settled)
    );

    rbe_const_div #(
        .DIVISOR(STEP), .D_W(D_W), .Q_W(MANT_W)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .load(to_divide),
        .dividend(diff), .quotient(quotient), .ready(div_ready)
    );

    rbe_burst_enc #(
        .BURST_W(BURST_W), .MANT_W(MANT_W), .EXP_MAX(EXP_MAX)
    ) u_burst (
        .burst(burst_q), .mant(b_mant), .expo(b_exp)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start)     state_nxt = ST_NORM;
            ST_NORM:   if (settled)   state_nxt = ST_DIVIDE;
            ST_DIVIDE: if (div_ready) state_nxt = ST_DONE;
            ST_DONE:                  state_nxt = ST_IDLE;
            default:                  state_nxt = ST_IDLE;
        endcase
    end

    // output and capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_q    <= '0;
            sat_q      <= 1'b0;
            rate_mant  <= '0;
            rate_exp   <= '0;
            rate_div   <= '0;
            burst_mant <= '0;
            burst_exp  <= '0;
        end else begin
            if (accept)    burst_q <= burst;
            if (to_divide) sat_q   <= (scaled >= HIGH_V);
            if (capture) begin
                rate_mant  <= sat_q ? '1 : quotient;
                rate_exp   <= (exp_cnt > EXP_LIM) ? EXP_LIM : exp_cnt;
                rate_div   <= div_cnt;
                burst_mant <= b_mant;
                burst_exp  <= b_exp;
            end
        end
    end
endmodule

// File: rtl/rbe_checker.sv
module rbe_checker #(
    parameter int MANT_W  = 8,
    parameter int EXP_W   = 5,
    parameter int DIV_W   = 5,
    parameter int BE_W    = 5,
    parameter int EXP_MAX = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [MANT_W-1:0] rate_mant,
    input logic [EXP_W-1:0]  rate_exp,
    input logic [DIV_W-1:0]  rate_div,
    input logic [MANT_W-1:0] burst_mant,
    input logic [BE_W-1:0]   burst_exp
);
    // R8: done lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: results move only together with done
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({rate_mant, rate_exp, rate_div, burst_mant, burst_exp}));

    // R3: rate exponent never beyond the clamp
    a_r3_exp_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rate_exp <= EXP_W'(EXP_MAX));

    // R1: a doubled rate never also reports an exponent
    a_r1_div_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_div != '0) |-> (rate_exp == '0));

    // R6: small bursts carry no mantissa
    a_r6_small_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_exp < BE_W'(MANT_W)) |-> (burst_mant == '0));

    // R7: burst exponent never beyond the clamp
    a_r7_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
        burst_exp <= BE_W'(EXP_MAX));
endmodule

bind rate_burst_encoder rbe_checker #(
    .MANT_W(MANT_W), .EXP_W(EXP_W), .DIV_W(DIV_W), .BE_W(BE_W), .EXP_MAX(EXP_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done),
    .rate_mant(rate_mant), .rate_exp(rate_exp), .rate_div(rate_div),
    .burst_mant(burst_mant), .burst_exp(burst_exp)
);

// File: tb/rate_burst_encoder_test.sv
module rate_burst_encoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] rate = '0;
    logic [31:0] burst = '0;
    logic        done;
    logic [7:0]  rate_mant, burst_mant;
    logic [4:0]  rate_exp, rate_div, burst_exp;

    int vectors = 0;
    int errors  = 0;

    always #4 clk = ~clk;

    rate_burst_encoder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .rate(rate), .burst(burst),
        .done(done), .rate_mant(rate_mant), .rate_exp(rate_exp),
        .rate_div(rate_div), .burst_mant(burst_mant), .burst_exp(burst_exp)
    );

    // expected result {rate_mant, rate_exp, rate_div, burst_mant, burst_exp}
    function automatic logic [30:0] model(input logic [63:0] r, input logic [31:0] b);
        logic [71:0] s;
        int dv, ex, rm, be, bm, top;
        s = {8'd0, r} * 72'd64;
        dv = 0; ex = 0;
        if (s < 72'd256000000) begin
            while (s < 72'd256000000 && dv < 31) begin s = s * 2; dv++; end
        end else begin
            while (s >= 72'd512000000 && ex <= 22) begin s = s / 2; ex++; end
            if (ex > 22) ex = 22;
        end
        if (s < 72'd256000000) rm = 0;
        else if (s >= 72'd512000000) rm = 255;
        else rm = int'((s - 72'd256000000) / 72'd1000000);
        top = 0;
        for (int i = 0; i < 32; i++) if (b[i]) top = i;
        if (b < 256) begin
            be = top; bm = 0;
        end else begin
            longint rest;
            be = (top > 22) ? 22 : top;
            rest = (longint'(b) - (longint'(1) << top)) >>> (be - 8);
            bm = (rest > 255) ? 255 : int'(rest);
        end
        return {8'(rm), 5'(ex), 5'(dv), 8'(bm), 5'(be)};
    endfunction

    task automatic check(input string req, input logic [30:0] act, input logic [30:0] exp_v);
        vectors++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    function automatic logic [30:0] outs();
        return {rate_mant, rate_exp, rate_div, burst_mant, burst_exp};
    endfunction

    // issue one request and check it; R1..R7 values, R8 pulse width
    task automatic run(input string req, input logic [63:0] r, input logic [31:0] b);
        int waited;
        @(negedge clk);
        rate = r; burst = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 100) begin @(negedge clk); waited++; end
        if (!done) begin
            errors++; vectors++;
            $display("FAIL R8 no done for rate=%h burst=%h actual=0 expected=1", r, b);
        end else begin
            check(req, outs(), model(r, b));
            @(negedge clk);
            check("R8 done one cycle", {30'd0, done}, 31'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset outputs", outs(), 31'd0);
        check("R10 reset done", {30'd0, done}, 31'd0);
        rst_n = 1'b1;

        // R1 rate zero hits the divider cap; R5 burst zero
        run("R1 R4 R5 zero inputs", 64'd0, 32'd0);
        // R1 R2 R3 every power of two of the rate, bursts across widths
        for (int k = 0; k < 64; k++) begin
            run("R1 R2 R3 R4 R7 power sweep", 64'd1 << k, 32'd1 << (k % 32));
            run("R1 R2 R4 R7 mixed sweep", (64'd1 << k) | (64'(k) * 64'd777777),
                32'(k) * 32'd2654435761);
        end
        // R4 decimal rates including exact window edges
        begin
            logic [63:0] r10 = 64'd1;
            for (int k = 0; k < 20; k++) begin
                run("R4 decade rates", r10, 32'd1000 * 32'(k + 1));
                r10 = r10 * 64'd10;
            end
        end
        run("R4 window low edge", 64'd4000000, 32'd255);
        run("R4 window just under high", 64'd7999999, 32'd256);
        run("R2 window high edge", 64'd8000000, 32'd257);
        run("R3 R4 saturate", 64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF);
        run("R7 clamp no remainder", 64'd12345, 32'd1 << 23);
        run("R7 clamp remainder", 64'd12345, 32'h00FF_FFFF);
        // R5 R6 R7 burst sweep across the 256 boundary
        for (int b = 0; b < 600; b++) run("R5 R6 R7 burst sweep", 64'd1000000, 32'(b));

        // R9 start while busy is ignored
        begin
            logic [30:0] held;
            int dones;
            @(negedge clk);
            rate = 64'd3; burst = 32'd70000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            rate = 64'd999999999; burst = 32'd5; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            dones = 0;
            for (int c = 0; c < 120; c++) begin
                if (done) begin
                    dones++;
                    if (dones == 1) check("R9 busy start results", outs(), model(64'd3, 32'd70000));
                end
                @(negedge clk);
            end
            check("R9 single done", 31'(dones), 31'd1);
            held = outs();
            rate = 64'd42; burst = 32'd4242;
            repeat (20) @(negedge clk);
            check("R8 outputs hold", outs(), held);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule